// File: doc/BRIEF.md
# Integer ALU Execute Unit

This block is the execute stage of a simple 32-bit integer pipeline. Each cycle it receives one instruction word together with the values already read from the two source registers. It decodes the word and computes the arithmetic, bitwise or shift result. On the next clock edge it presents that result with the destination register index, a write strobe, a signed-overflow exception flag and an illegal-instruction flag.

Two instruction shapes are recognised. The register shape carries a zero major opcode and selects its operation with a low function field. The immediate shape carries a 16-bit constant, which is widened by sign or zero extension according to the operation. Adds and subtracts come in a trapping flavour and a wrapping flavour. A trapping operation that overflows raises the exception and suppresses its own register write. The register file, exception sequencing, memory and control flow are handled elsewhere.

Top module: `exu_top`

## Requirements
- R1: While `rst` is high at a rising edge, every output is zero after that edge.
- R2: Register-shape funct 0x20 and 0x21 return rs+rt, and funct 0x22 and 0x23 return rs-rt, all modulo 2^32.
- R3: Funct 0x20, funct 0x22 and opcode 0x08 set `ovf_o` and clear `wr_en_o` when the signed result does not fit in 32 bits. Funct 0x21, funct 0x23 and opcode 0x09 never set `ovf_o`.
- R4: Funct 0x24, 0x25, 0x26 and 0x27 return the bitwise AND, OR, XOR and NOR of rs and rt.
- R5: Funct 0, 2 and 3 shift rt by instr[10:6]: left with zero fill, right with zero fill, and right with sign fill. For example, 0xabcd1234 shifted right with sign fill by 4 gives 0xfabcd123.
- R6: Funct 4, 6 and 7 perform the same three shifts on rt, with the amount taken from the low 5 bits of rs.
- R7: Opcodes 0x08 and 0x09 add rs to the sign-extended instr[15:0].
- R8: Opcodes 0x0c, 0x0d and 0x0e return rs AND, OR and XOR the zero-extended instr[15:0].
- R9: Opcode 0x0f returns instr[15:0] in bits 31:16 and zero in bits 15:0, whatever rs holds.
- R10: `wr_idx_o` is instr[15:11] for the register shape (opcode 0) and instr[20:16] for the immediate shape. `wr_en_o` is low whenever that index is 0.
- R11: Any other opcode, or opcode 0 with any other funct, sets `illegal_o` and drives `wr_en_o`, `ovf_o`, `wr_idx_o` and `result_o` to zero.
- R12: The outputs reflect the inputs sampled at the previous rising edge, with one cycle of latency and a new instruction accepted every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| rs_val_i | input | 32 | Value of the first source register |
| rt_val_i | input | 32 | Value of the second source register |
| result_o | output | 32 | Computed result |
| wr_en_o | output | 1 | Destination write strobe |
| wr_idx_o | output | 5 | Destination register index |
| ovf_o | output | 1 | Signed-overflow exception |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The only state in the block is the single output register, so a wrong decode or a wrong datapath choice shows up at the ports one cycle after the instruction arrives. Such a fault appears as a wrong result word, a write strobe that should have been blocked, or a swapped destination field. A behavioural reference model in the bench predicts every output each cycle. The bench covers the corners where an error is easy to miss: the overflow boundaries in both directions, the extension of 0x8000 and 0xffff immediates, shift amounts whose upper rs bits must be ignored, and destination index zero.

// File: rtl/exu_pkg.sv
package exu_pkg;

    localparam int XLEN   = 32;
    localparam int IDX_W  = 5;
    localparam int SHW    = $clog2(XLEN);
    localparam int IMM_W  = 16;
    localparam int CODE_W = 6;

    localparam logic [CODE_W-1:0] OPC_REG   = 6'h00;
    localparam logic [CODE_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [CODE_W-1:0] OPC_ADDIU = 6'h09;
    localparam logic [CODE_W-1:0] OPC_ANDI  = 6'h0c;
    localparam logic [CODE_W-1:0] OPC_ORI   = 6'h0d;
    localparam logic [CODE_W-1:0] OPC_XORI  = 6'h0e;
    localparam logic [CODE_W-1:0] OPC_LUI   = 6'h0f;

    localparam logic [CODE_W-1:0] FN_SLL  = 6'h00;
    localparam logic [CODE_W-1:0] FN_SRL  = 6'h02;
    localparam logic [CODE_W-1:0] FN_SRA  = 6'h03;
    localparam logic [CODE_W-1:0] FN_SLLV = 6'h04;
    localparam logic [CODE_W-1:0] FN_SRLV = 6'h06;
    localparam logic [CODE_W-1:0] FN_SRAV = 6'h07;
    localparam logic [CODE_W-1:0] FN_ADD  = 6'h20;
    localparam logic [CODE_W-1:0] FN_ADDU = 6'h21;
    localparam logic [CODE_W-1:0] FN_SUB  = 6'h22;
    localparam logic [CODE_W-1:0] FN_SUBU = 6'h23;
    localparam logic [CODE_W-1:0] FN_AND  = 6'h24;
    localparam logic [CODE_W-1:0] FN_OR   = 6'h25;
    localparam logic [CODE_W-1:0] FN_XOR  = 6'h26;
    localparam logic [CODE_W-1:0] FN_NOR  = 6'h27;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR,
        K_SHL, K_SHR_LOG, K_SHR_ARI, K_UPPER
    } kind_e;

    typedef enum logic [1:0] {
        B_REG, B_SEXT, B_ZEXT
    } bsel_e;

    typedef struct packed {
        logic             legal;
        kind_e            kind;
        bsel_e            bsel;
        logic             var_amt;
        logic             trap;
        logic [IDX_W-1:0] dst;
    } ctl_t;

    typedef struct packed {
        logic [XLEN-1:0]  value;
        logic             wen;
        logic [IDX_W-1:0] idx;
        logic             ovf;
        logic             ill;
    } wb_t;

    function automatic logic [CODE_W-1:0] f_opcode(input logic [31:0] w);
        return w[31:26];
    endfunction

    function automatic logic [CODE_W-1:0] f_funct(input logic [31:0] w);
        return w[5:0];
    endfunction

    function automatic logic [SHW-1:0] f_shamt(input logic [31:0] w);
        return w[10:6];
    endfunction

    function automatic logic [XLEN-1:0] f_sext(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){v[IMM_W-1]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] f_zext(input logic [IMM_W-1:0] v);
        return {{(XLEN-IMM_W){1'b0}}, v};
    endfunction

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [31:0] instr,
    output ctl_t        ctl
);
    logic [CODE_W-1:0] opc;
    logic [CODE_W-1:0] fn;

    assign opc = f_opcode(instr);
    assign fn  = f_funct(instr);

    always_comb begin
        ctl         = '0;
        ctl.kind    = K_ADD;
        ctl.bsel    = B_REG;
        ctl.legal   = 1'b1;
        if (opc == OPC_REG) begin
            ctl.dst = instr[15:11];
            unique case (fn)
                FN_ADD:  begin ctl.kind = K_ADD; ctl.trap = 1'b1; end
                FN_ADDU: ctl.kind = K_ADD;
                FN_SUB:  begin ctl.kind = K_SUB; ctl.trap = 1'b1; end
                FN_SUBU: ctl.kind = K_SUB;
                FN_AND:  ctl.kind = K_AND;
                FN_OR:   ctl.kind = K_OR;
                FN_XOR:  ctl.kind = K_XOR;
                FN_NOR:  ctl.kind = K_NOR;
                FN_SLL:  ctl.kind = K_SHL;
                FN_SRL:  ctl.kind = K_SHR_LOG;
                FN_SRA:  ctl.kind = K_SHR_ARI;
                FN_SLLV: begin ctl.kind = K_SHL;     ctl.var_amt = 1'b1; end
                FN_SRLV: begin ctl.kind = K_SHR_LOG; ctl.var_amt = 1'b1; end
                FN_SRAV: begin ctl.kind = K_SHR_ARI; ctl.var_amt = 1'b1; end
                default: ctl.legal = 1'b0;
            endcase
        end else begin
            ctl.dst = instr[20:16];
            unique case (opc)
                OPC_ADDI:  begin ctl.kind = K_ADD; ctl.bsel = B_SEXT; ctl.trap = 1'b1; end
                OPC_ADDIU: begin ctl.kind = K_ADD; ctl.bsel = B_SEXT; end
                OPC_ANDI:  begin ctl.kind = K_AND; ctl.bsel = B_ZEXT; end
                OPC_ORI:   begin ctl.kind = K_OR;  ctl.bsel = B_ZEXT; end
                OPC_XORI:  begin ctl.kind = K_XOR; ctl.bsel = B_ZEXT; end
                OPC_LUI:   ctl.kind = K_UPPER;
                default:   ctl.legal = 1'b0;
            endcase
        end
        if (!ctl.legal) begin
            ctl.dst  = '0;
            ctl.trap = 1'b0;
        end
    end
endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);
    logic [W-1:0] b_eff;

    assign b_eff = sub ? ~b : b;
    assign sum   = a + b_eff + {{(W-1){1'b0}}, sub};
    // operands of equal effective sign producing a result of the other sign
    assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
    parameter int W   = 32,
    parameter int AMT = $clog2(W)
) (
    input  logic [W-1:0]   data,
    input  logic [AMT-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   out
);
    logic [W-1:0] st [0:AMT];
    logic         fill;

    assign fill  = arith & data[W-1];
    assign st[0] = data;

    for (genvar s = 0; s < AMT; s++) begin : g_stage
        localparam int SH = 1 << s;
        logic [W-1:0] moved;
        assign moved     = left ? {st[s][W-1-SH:0], {SH{1'b0}}}
                                : {{SH{fill}}, st[s][W-1:SH]};
        assign st[s+1]   = amt[s] ? moved : st[s];
    end

    assign out = st[AMT];
endmodule

// File: rtl/exu_top.sv
module exu_top
    import exu_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] result_o,
    output logic        wr_en_o,
    output logic [4:0]  wr_idx_o,
    output logic        ovf_o,
    output logic        illegal_o
);
    ctl_t            ctl;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] as_sum;
    logic            as_ovf;
    logic [XLEN-1:0] sh_out;
    logic [SHW-1:0]  sh_amt;
    logic [XLEN-1:0] res;
    wb_t             wb_d;
    wb_t             wb_q;

    exu_decode u_dec (
        .instr (instr_i),
        .ctl   (ctl)
    );

    always_comb begin
        unique case (ctl.bsel)
            B_SEXT:  opnd_b = f_sext(instr_i[IMM_W-1:0]);
            B_ZEXT:  opnd_b = f_zext(instr_i[IMM_W-1:0]);
            default: opnd_b = rt_val_i;
        endcase
    end

    exu_addsub #(.W(XLEN)) u_as (
        .a   (rs_val_i),
        .b   (opnd_b),
        .sub (ctl.kind == K_SUB),
        .sum (as_sum),
        .ovf (as_ovf)
    );

    assign sh_amt = ctl.var_amt ? rs_val_i[SHW-1:0] : f_shamt(instr_i);

    exu_shift #(.W(XLEN), .AMT(SHW)) u_sh (
        .data  (rt_val_i),
        .amt   (sh_amt),
        .left  (ctl.kind == K_SHL),
        .arith (ctl.kind == K_SHR_ARI),
        .out   (sh_out)
    );

    always_comb begin
        unique case (ctl.kind)
            K_ADD, K_SUB: res = as_sum;
            K_AND:        res = rs_val_i & opnd_b;
            K_OR:         res = rs_val_i | opnd_b;
            K_XOR:        res = rs_val_i ^ opnd_b;
            K_NOR:        res = ~(rs_val_i | opnd_b);
            K_UPPER:      res = {instr_i[IMM_W-1:0], {(XLEN-IMM_W){1'b0}}};
            default:      res = sh_out;
        endcase
    end

    always_comb begin
        wb_d.ill   = !ctl.legal;
        wb_d.ovf   = ctl.legal && ctl.trap && as_ovf;
        wb_d.idx   = ctl.dst;
        wb_d.value = ctl.legal ? res : '0;
        wb_d.wen   = ctl.legal && !wb_d.ovf && (ctl.dst != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) wb_q <= '0;
        else     wb_q <= wb_d;
    end

    assign result_o  = wb_q.value;
    assign wr_en_o   = wb_q.wen;
    assign wr_idx_o  = wb_q.idx;
    assign ovf_o     = wb_q.ovf;
    assign illegal_o = wb_q.ill;
endmodule

// File: rtl/exu_chk.sv
module exu_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] instr_i,
    input logic [31:0] result_o,
    input logic        wr_en_o,
    input logic [4:0]  wr_idx_o,
    input logic        ovf_o,
    input logic        illegal_o
);
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (result_o == 32'd0 && !wr_en_o && wr_idx_o == 5'd0 && !ovf_o && !illegal_o));

    a_r3_ovf_blocks_write: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> !wr_en_o);

    a_r3_wrap_no_ovf: assert property (@(posedge clk) disable iff (rst)
        ($past(instr_i[31:26]) == 6'h09) |-> !ovf_o);

    a_r9_upper_half: assert property (@(posedge clk) disable iff (rst)
        ($past(instr_i[31:26]) == 6'h0f) |-> (result_o == {$past(instr_i[15:0]), 16'h0000}));

    a_r10_zero_dst: assert property (@(posedge clk) disable iff (rst)
        wr_en_o |-> (wr_idx_o != 5'd0));

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!wr_en_o && !ovf_o && result_o == 32'd0 && wr_idx_o == 5'd0));
endmodule

bind exu_top exu_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .instr_i   (instr_i),
    .result_o  (result_o),
    .wr_en_o   (wr_en_o),
    .wr_idx_o  (wr_idx_o),
    .ovf_o     (ovf_o),
    .illegal_o (illegal_o)
);

// File: tb/exu_top_tb.sv
`timescale 1ns/1ps
module exu_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr_i  = 32'h0;
    logic [31:0] rs_val_i = 32'h0;
    logic [31:0] rt_val_i = 32'h0;
    logic [31:0] result_o;
    logic        wr_en_o;
    logic [4:0]  wr_idx_o;
    logic        ovf_o;
    logic        illegal_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 0;

    logic [31:0] e_res;
    logic        e_we;
    logic [4:0]  e_idx;
    logic        e_ov;
    logic        e_il;
    string       e_tag;
    bit          have_exp = 0;

    always #2 clk = ~clk;

    exu_top u_dut (
        .clk(clk), .rst(rst), .instr_i(instr_i), .rs_val_i(rs_val_i),
        .rt_val_i(rt_val_i), .result_o(result_o), .wr_en_o(wr_en_o),
        .wr_idx_o(wr_idx_o), .ovf_o(ovf_o), .illegal_o(illegal_o)
    );

    function automatic logic [31:0] rt_ins(input logic [5:0] fn, input logic [4:0] rd,
                                           input logic [4:0] sh);
        return {6'h00, 5'd3, 5'd4, rd, sh, fn};
    endfunction

    function automatic logic [31:0] im_ins(input logic [5:0] opc, input logic [4:0] rt,
                                           input logic [15:0] imm);
        return {opc, 5'd6, rt, imm};
    endfunction

    task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b);
        logic [5:0]  opc = ins[31:26];
        logic [5:0]  fn  = ins[5:0];
        logic [4:0]  sh  = ins[10:6];
        logic [15:0] imm = ins[15:0];
        logic [4:0]  dst;
        longint sa = longint'($signed(a));
        longint sb = longint'($signed(b));
        longint si = longint'($signed(imm));
        longint s  = 0;
        bit trap = 0;
        bit il   = 0;
        logic [31:0] r = 0;
        if (opc == 6'h00) begin
            dst = ins[15:11];
            case (fn)
                6'h20: begin s = sa + sb; r = a + b; trap = 1; end
                6'h21: r = a + b;
                6'h22: begin s = sa - sb; r = a - b; trap = 1; end
                6'h23: r = a - b;
                6'h24: r = a & b;
                6'h25: r = a | b;
                6'h26: r = a ^ b;
                6'h27: r = ~(a | b);
                6'h00: r = b << sh;
                6'h02: r = b >> sh;
                6'h03: r = 32'($signed(b) >>> sh);
                6'h04: r = b << a[4:0];
                6'h06: r = b >> a[4:0];
                6'h07: r = 32'($signed(b) >>> a[4:0]);
                default: il = 1;
            endcase
        end else begin
            dst = ins[20:16];
            case (opc)
                6'h08: begin s = sa + si; r = a + 32'(si); trap = 1; end
                6'h09: r = a + 32'(si);
                6'h0c: r = a & {16'h0, imm};
                6'h0d: r = a | {16'h0, imm};
                6'h0e: r = a ^ {16'h0, imm};
                6'h0f: r = {imm, 16'h0};
                default: il = 1;
            endcase
        end
        if (il) begin
            e_res = 0; e_we = 0; e_idx = 0; e_ov = 0; e_il = 1;
        end else begin
            e_ov  = trap && (s > 64'sd2147483647 || s < -64'sd2147483648);
            e_res = r;
            e_idx = dst;
            e_we  = !e_ov && (dst != 0);
            e_il  = 0;
        end
    endtask

    task automatic compare();
        checks++;
        if (result_o !== e_res || wr_en_o !== e_we || wr_idx_o !== e_idx ||
            ovf_o !== e_ov || illegal_o !== e_il) begin
            failures++;
            $display("FAIL %s: got res=%h we=%b idx=%0d ovf=%b ill=%b, expected res=%h we=%b idx=%0d ovf=%b ill=%b",
                     e_tag, result_o, wr_en_o, wr_idx_o, ovf_o, illegal_o,
                     e_res, e_we, e_idx, e_ov, e_il);
        end
    endtask

    task automatic check_zero(input string tag);
        checks++;
        if (result_o !== 0 || wr_en_o !== 0 || wr_idx_o !== 0 || ovf_o !== 0 || illegal_o !== 0) begin
            failures++;
            $display("FAIL %s: got res=%h we=%b idx=%0d ovf=%b ill=%b, expected all zero",
                     tag, result_o, wr_en_o, wr_idx_o, ovf_o, illegal_o);
        end
    endtask

    task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
        @(negedge clk);
        if (have_exp) compare();
        instr_i = ins; rs_val_i = a; rt_val_i = b;
        model(ins, a, b);
        e_tag = tag;
        have_exp = 1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_exp) compare();
        have_exp = 0;
    endtask

    initial begin
        instr_i = rt_ins(6'h20, 5'd9, 5'd0); rs_val_i = 32'h7fffffff; rt_val_i = 32'h1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check_zero("R1 reset state");
        rst = 1'b0;

        // R2 wrapping and non-trapping arithmetic
        step(rt_ins(6'h21, 5'd9, 5'd0), 32'd5, 32'd7, "R2 addu");
        step(rt_ins(6'h23, 5'd9, 5'd0), 32'd3, 32'd5, "R2 subu negative");
        step(rt_ins(6'h20, 5'd9, 5'd0), 32'd100, 32'hffffffe2, "R2 add no overflow");
        step(rt_ins(6'h22, 5'd9, 5'd0), 32'h80000000, 32'h80000000, "R2 sub equal");
        // R3 overflow trapping
        step(rt_ins(6'h20, 5'd9, 5'd0), 32'h7fffffff, 32'h1, "R3 add positive overflow");
        step(rt_ins(6'h20, 5'd9, 5'd0), 32'h80000000, 32'hffffffff, "R3 add negative overflow");
        step(rt_ins(6'h22, 5'd9, 5'd0), 32'h80000000, 32'h1, "R3 sub overflow");
        step(rt_ins(6'h22, 5'd9, 5'd0), 32'h7fffffff, 32'hffffffff, "R3 sub pos-neg overflow");
        step(rt_ins(6'h22, 5'd9, 5'd0), 32'hffffffff, 32'h7fffffff, "R3 sub boundary no overflow");
        step(rt_ins(6'h21, 5'd9, 5'd0), 32'h7fffffff, 32'h1, "R3 addu ignores overflow");
        step(rt_ins(6'h23, 5'd9, 5'd0), 32'h80000000, 32'h1, "R3 subu ignores overflow");
        step(im_ins(6'h08, 5'd9, 16'h0001), 32'h7fffffff, 32'h0, "R3 addi overflow");
        step(im_ins(6'h09, 5'd9, 16'h0001), 32'h7fffffff, 32'h0, "R3 addiu ignores overflow");
        // R4 bitwise
        step(rt_ins(6'h24, 5'd8, 5'd0), 32'habcd1234, 32'hffff0000, "R4 and");
        step(rt_ins(6'h25, 5'd8, 5'd0), 32'habcd1234, 32'hffff0000, "R4 or");
        step(rt_ins(6'h26, 5'd8, 5'd0), 32'habcd1234, 32'hffff0000, "R4 xor");
        step(rt_ins(6'h27, 5'd8, 5'd0), 32'habcd1234, 32'hffff0000, "R4 nor");
        // R5 constant shifts
        step(rt_ins(6'h00, 5'd9, 5'd8), 32'hffffffff, 32'habcd1234, "R5 sll 8");
        step(rt_ins(6'h02, 5'd9, 5'd4), 32'h0, 32'habcd1234, "R5 srl 4");
        step(rt_ins(6'h03, 5'd9, 5'd4), 32'h0, 32'habcd1234, "R5 sra 4");
        step(rt_ins(6'h03, 5'd9, 5'd31), 32'h0, 32'h7fffffff, "R5 sra 31 positive");
        step(rt_ins(6'h03, 5'd9, 5'd31), 32'h0, 32'h80000000, "R5 sra 31 negative");
        // R6 variable shifts
        step(rt_ins(6'h06, 5'd9, 5'd0), 32'd16, 32'habcd1234, "R6 srlv 16");
        step(rt_ins(6'h07, 5'd9, 5'd0), 32'hffffffe4, 32'habcd1234, "R6 srav upper bits ignored");
        step(rt_ins(6'h04, 5'd9, 5'd7), 32'h00000020, 32'habcd1234, "R6 sllv amount 32 wraps to 0");
        step(rt_ins(6'h04, 5'd9, 5'd0), 32'h00000003, 32'h80000001, "R6 sllv 3");
        // R7 sign-extended immediates
        step(im_ins(6'h09, 5'd10, 16'hffff), 32'd10, 32'h0, "R7 addiu minus one");
        step(im_ins(6'h08, 5'd10, 16'h8000), 32'd0, 32'h0, "R7 addi 0x8000");
        // R8 zero-extended immediates
        step(im_ins(6'h0c, 5'd10, 16'h000f), 32'hffffffff, 32'h0, "R8 andi");
        step(im_ins(6'h0d, 5'd10, 16'h8000), 32'h00000001, 32'h0, "R8 ori no sign fill");
        step(im_ins(6'h0e, 5'd10, 16'hffff), 32'h12345678, 32'h0, "R8 xori");
        // R9 load upper
        step(im_ins(6'h0f, 5'd10, 16'hac51), 32'hdeadbeef, 32'h0, "R9 lui");
        step(im_ins(6'h0d, 5'd10, 16'h65d9), 32'hac510000, 32'h0, "R9 lui then ori");
        // R10 destination selection and index zero
        step(rt_ins(6'h21, 5'd17, 5'd0), 32'd1, 32'd2, "R10 rd index 17");
        step(im_ins(6'h09, 5'd9, 16'h0003), 32'd1, 32'd2, "R10 rt index 9");
        step(rt_ins(6'h21, 5'd0, 5'd0), 32'd1, 32'd2, "R10 rd zero no write");
        step(im_ins(6'h09, 5'd0, 16'h0003), 32'd1, 32'd2, "R10 rt zero no write");
        step(rt_ins(6'h20, 5'd0, 5'd0), 32'h7fffffff, 32'd1, "R10 overflow to index zero");
        // R11 illegal encodings
        step(rt_ins(6'h01, 5'd9, 5'd0), 32'd1, 32'd2, "R11 funct 0x01");
        step(rt_ins(6'h05, 5'd9, 5'd0), 32'd1, 32'd2, "R11 funct 0x05");
        step(rt_ins(6'h18, 5'd9, 5'd0), 32'd1, 32'd2, "R11 funct 0x18");
        step(im_ins(6'h23, 5'd9, 16'h0004), 32'd1, 32'd2, "R11 opcode 0x23");
        step(im_ins(6'h3f, 5'd9, 16'h0004), 32'h7fffffff, 32'd2, "R11 opcode 0x3f");
        step(im_ins(6'h0a, 5'd9, 16'h0004), 32'd1, 32'd2, "R11 opcode 0x0a");
        // R12 back-to-back random mix
        for (int i = 0; i < 400; i++) begin
            logic [5:0] fns [14] = '{6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h26,
                                     6'h27, 6'h00, 6'h02, 6'h03, 6'h04, 6'h06, 6'h07};
            logic [5:0] opcs [6] = '{6'h08, 6'h09, 6'h0c, 6'h0d, 6'h0e, 6'h0f};
            logic [31:0] w = $urandom;
            logic [31:0] ins;
            if (w[31]) ins = {6'h00, w[25:6], fns[w[3:0] % 14]};
            else       ins = {opcs[w[2:0] % 6], w[25:0]};
            step(ins, $urandom, $urandom, "R12 random stream");
        end
        flush();
        // R1 reset in mid-stream
        step(rt_ins(6'h21, 5'd9, 5'd0), 32'd4, 32'd4, "R12 before reset");
        @(negedge clk);
        compare();
        have_exp = 0;
        rst = 1'b1;
        instr_i = rt_ins(6'h21, 5'd9, 5'd0);
        @(negedge clk);
        check_zero("R1 mid-run reset");
        rst = 1'b0;
        step(rt_ins(6'h25, 5'd12, 5'd0), 32'hf0, 32'h0f, "R1 first after reset");
        flush();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule